// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from five external pins and reduces them to one 3-bit priority code for a 68000-style processor. Every source has a fixed priority level from 1 to 6. A debug request always sits alone at level 7 and cannot be masked. When the processor runs an acknowledge cycle for a level, the block returns a vector number. That number is the programmable vector base plus the index of the winning source.

An in-service record gives nested handling. Acknowledging a level marks it as being serviced. After that, only strictly higher levels are presented until software writes the end-of-service register. Each external pin can be set to active-high or active-low, and to level or edge sensing. Edge pending bits stay set until software clears them. A wake-up enable register, separate from the normal enable register, selects which sources drive a combinational wake output while the processor clock is stopped.

Software reaches six registers through a small synchronous write port and a combinational read port: enable, wake enable, status, pin configuration, vector base and in-service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `ipl` is 0 and `wake` is 0. The enable, wake-enable and pin configuration registers read 0, and the vector base (address 4) reads 0x40.
- R2: Source index i is external pin i for i in 0..4, and internal request i-5 for i in 5..12. Pin k has level k+1. Internal request j has level (j mod 6)+1. `ipl` equals the highest level among the sources that are both pending and enabled.
- R3: While `iack_lvl` names a level that has pending enabled sources, `vec` equals the vector base plus the lowest source index at that level, modulo 256.
- R4: When no pending enabled source exists at `iack_lvl`, `vec` reads the spurious vector 24.
- R5: Bit i of the enable register (address 0) gates source i out of `ipl` and `vec`. The status register (address 2) still shows the source's pending bit i.
- R6: Bits 8+k of the configuration register (address 3) make pin k active-low. With bit k clear, the pin is level-sensed and its status bit follows the active pin value in the same cycle.
- R7: With configuration bit k set, pin k is edge-sensed. An inactive-to-active transition sets status bit k at the next clock edge. The bit stays set after the pin returns inactive and ignores a write of 0. Writing 1 to status bit k clears it.
- R8: A pulse on `iack` marks `iack_lvl` in service (readable at address 5). Levels 1..6 reach `ipl` only when they are above the highest in-service level. Any write to address 5 removes the highest in-service level.
- R9: `dbg_req` forces `ipl` to 7 whatever the masks and the in-service levels are. An acknowledge at level 7 then returns vector base plus 13.
- R10: `wake` is high, combinationally, when `dbg_req` is high or any source whose status bit is set has its bit set in the wake-enable register (address 1). The normal enable register has no effect on `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq | input | 5 | External interrupt pins |
| int_req | input | 8 | Internal peripheral level requests |
| dbg_req | input | 1 | Debug request, level 7, unmaskable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| iack | input | 1 | One-cycle acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| ipl | output | 3 | Presented priority level, 0 = none |
| vec | output | 8 | Vector number for `iack_lvl` |
| wake | output | 1 | Wake-up request |

## Verification
The hardest state to reach from the ports is a stack of two in-service levels, with a request still pending underneath, while an end-of-service write removes only the top entry. The bench acknowledges a level-2 source, raises a level-5 pin and acknowledges it too. It then retires the levels one at a time and checks after each step that `ipl` stays hidden or reappears exactly as the stack allows. Edge latching is also difficult because it depends on a pin transition in relation to a clear write. The pin is toggled across clock edges, and the status bit is read between a write of 0 and a write of 1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam logic [7:0] SPUR_VEC = 8'd24;

  // priority level of a source index
  function automatic logic [2:0] src_level(input int idx, input int n_ext, input int n_int);
    if (idx < n_ext)              return 3'(idx + 1);
    else if (idx < n_ext + n_int) return 3'(((idx - n_ext) % 6) + 1);
    else                          return 3'd7;
  endfunction

  function automatic logic [7:0] vec_calc(input logic [7:0] base, input int idx);
    return base + 8'(idx);
  endfunction

endpackage

// File: rtl/irqc_pin_cond.sv
module irqc_pin_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic act_low,
  input  logic clr,
  output logic req
);
  logic act, act_q, pend, edge_set;

  assign act      = pin ^ act_low;
  assign edge_set = edge_mode & act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      act_q <= act;
      pend  <= edge_set | (pend & ~clr);
    end
  end

  assign req = edge_mode ? pend : act;

  // R7: a latched edge survives until a clearing write
  a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic [2:0] ack_lvl,
  input  logic       eoi,
  output logic [7:0] isr,
  output logic [2:0] top
);
  logic [7:0] isr_nx;

  always_comb begin
    top = 3'd0;
    for (int l = 1; l < 8; l++)
      if (isr[l]) top = 3'(l);
  end

  always_comb begin
    isr_nx = isr;
    if (eoi && top != 3'd0) isr_nx[top] = 1'b0;
    if (ack) isr_nx[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= 8'd0;
    else        isr <= isr_nx;
  end

  // R8: an acknowledge leaves its level in service
  a_r8_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> isr[$past(ack_lvl)]);

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
  import irqc_pkg::*;
#(
  parameter int N_EXT = 5,
  parameter int N_INT = 8,
  localparam int N_SRC = N_EXT + N_INT
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] live,
  input  logic             dbg,
  input  logic [2:0]       isr_top,
  input  logic [2:0]       ack_lvl,
  input  logic [7:0]       vbase,
  output logic [2:0]       ipl,
  output logic [7:0]       vec
);
  logic [2:0] best;
  logic       hit;
  int         win;

  always_comb begin
    best = 3'd0;
    for (int i = 0; i < N_SRC; i++)
      if (live[i] && src_level(i, N_EXT, N_INT) > best) best = src_level(i, N_EXT, N_INT);
  end

  assign ipl = dbg ? 3'd7 : ((best > isr_top) ? best : 3'd0);

  always_comb begin
    hit = 1'b0;
    win = 0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (live[i] && src_level(i, N_EXT, N_INT) == ack_lvl) begin
        hit = 1'b1;
        win = i;
      end
    if (ack_lvl == 3'd7 && dbg) begin
      hit = 1'b1;
      win = N_SRC;
    end
  end

  assign vec = hit ? vec_calc(vbase, win) : SPUR_VEC;

  // R9: debug always on top
  a_r9_dbg_top: assert property (@(posedge clk) disable iff (!rst_n)
    dbg |-> ipl == 3'd7);
  // R2: nothing live means nothing presented
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0 && !dbg) |-> ipl == 3'd0);
  // R8: a presented normal level is above the in-service level
  a_r8_above_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl != 3'd0 && ipl != 3'd7) |-> ipl > isr_top);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int         N_EXT  = 5,
  parameter int         N_INT  = 8,
  parameter int         DW     = 16,
  parameter logic [7:0] VB_RST = 8'h40
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_INT-1:0] int_req,
  input  logic             dbg_req,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             iack,
  input  logic [2:0]       iack_lvl,
  output logic [2:0]       ipl,
  output logic [7:0]       vec,
  output logic             wake
);
  localparam int N_SRC   = N_EXT + N_INT;
  localparam int POL_OFS = DW / 2;

  localparam logic [2:0] A_EN = 3'd0, A_WK = 3'd1, A_ST = 3'd2,
                         A_CF = 3'd3, A_VB = 3'd4, A_IS = 3'd5;

  logic [N_SRC-1:0] en_r, wk_r, raw, live;
  logic [N_EXT-1:0] edge_r, pol_r, ext_req, clr;
  logic [7:0]       vbase, isr;
  logic [2:0]       isr_top;
  logic             eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= '0;
      wk_r   <= '0;
      edge_r <= '0;
      pol_r  <= '0;
      vbase  <= VB_RST;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN: en_r  <= reg_wdata[N_SRC-1:0];
        A_WK: wk_r  <= reg_wdata[N_SRC-1:0];
        A_CF: begin
          edge_r <= reg_wdata[N_EXT-1:0];
          pol_r  <= reg_wdata[POL_OFS +: N_EXT];
        end
        A_VB: vbase <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  assign clr = (reg_wr && reg_addr == A_ST) ? reg_wdata[N_EXT-1:0] : '0;
  assign eoi = reg_wr && reg_addr == A_IS;

  for (genvar k = 0; k < N_EXT; k++) begin : g_pin
    irqc_pin_cond u_pin (
      .clk(clk), .rst_n(rst_n), .pin(ext_irq[k]),
      .edge_mode(edge_r[k]), .act_low(pol_r[k]), .clr(clr[k]),
      .req(ext_req[k])
    );
  end

  assign raw  = {int_req, ext_req};
  assign live = raw & en_r;
  assign wake = dbg_req | (|(raw & wk_r));

  irqc_nest u_nest (
    .clk(clk), .rst_n(rst_n), .ack(iack), .ack_lvl(iack_lvl),
    .eoi(eoi), .isr(isr), .top(isr_top)
  );

  irqc_resolve #(.N_EXT(N_EXT), .N_INT(N_INT)) u_res (
    .clk(clk), .rst_n(rst_n), .live(live), .dbg(dbg_req),
    .isr_top(isr_top), .ack_lvl(iack_lvl), .vbase(vbase),
    .ipl(ipl), .vec(vec)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN: reg_rdata[N_SRC-1:0] = en_r;
      A_WK: reg_rdata[N_SRC-1:0] = wk_r;
      A_ST: reg_rdata[N_SRC-1:0] = raw;
      A_CF: begin
        reg_rdata[N_EXT-1:0]         = edge_r;
        reg_rdata[POL_OFS +: N_EXT]  = pol_r;
      end
      A_VB: reg_rdata[7:0] = vbase;
      A_IS: reg_rdata[7:0] = isr;
      default: ;
    endcase
  end

  // R10: a wake-enabled pending source must raise wake
  a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_req & wk_r[N_EXT-1:0]) != '0) |-> wake);
  // R4: the spurious vector is never produced while that level has a live source
  a_r4_no_false_spur: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_lvl == 3'd7 && dbg_req) |-> vec != SPUR_VEC || vbase == 8'(SPUR_VEC - 8'(N_SRC)));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  ext_irq = 0;
  logic [7:0]  int_req = 0;
  logic        dbg_req = 0, reg_wr = 0, iack = 0;
  logic [2:0]  reg_addr = 0, iack_lvl = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  ipl;
  logic [7:0]  vec;
  logic        wake;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl u0 (.*);

  typedef struct packed {
    logic [4:0]  ext;
    logic [7:0]  intr;
    logic [15:0] en;
    logic [2:0]  exp;
  } row_t;

  // R2 / R5 level-sensed table
  localparam row_t TBL [8] = '{
    '{5'b00001, 8'h00, 16'hFFFF, 3'd1},
    '{5'b10001, 8'h00, 16'hFFFF, 3'd5},
    '{5'b00000, 8'h20, 16'hFFFF, 3'd6},
    '{5'b00000, 8'h20, 16'hFBFF, 3'd0},
    '{5'b01000, 8'h41, 16'hFFFF, 3'd4},
    '{5'b00000, 8'h80, 16'hFFFF, 3'd2},
    '{5'b11111, 8'hFF, 16'h0000, 3'd0},
    '{5'b00100, 8'h10, 16'hFDFF, 3'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk);
    iack = 1; iack_lvl = l;
    @(negedge clk);
    iack = 0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 ipl", ipl, 0);
    chk("R1 wake", wake, 0);
    rd(3'd0, d); chk("R1 enable", d, 0);
    rd(3'd1, d); chk("R1 wake-enable", d, 0);
    rd(3'd3, d); chk("R1 config", d, 0);
    rd(3'd4, d); chk("R1 vbase", d, 16'h40);

    // R2 / R5 table
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, TBL[i].en);
      ext_irq = TBL[i].ext; int_req = TBL[i].intr;
      settle();
      chk($sformatf("R2 row %0d ipl", i), ipl, TBL[i].exp);
    end
    ext_irq = 0; int_req = 0;

    // R5 masked source shows in status
    wr(3'd0, 16'h0000);
    int_req = 8'h20;
    settle();
    rd(3'd2, d); chk("R5 status bit10", d[10], 1);
    chk("R5 masked ipl", ipl, 0);
    int_req = 0;

    // R3 lowest index in level, base + index
    wr(3'd0, 16'hFFFF);
    wr(3'd4, 16'h0080);
    ext_irq = 5'b00010; int_req = 8'h82; iack_lvl = 3'd2;
    settle();
    chk("R3 vec pin1", vec, 8'h81);
    ext_irq = 0;
    settle();
    chk("R3 vec int1", vec, 8'h86);
    wr(3'd4, 16'h00FE);
    settle();
    chk("R3 vec wrap", vec, 8'h04);
    wr(3'd4, 16'h0080);
    int_req = 0;

    // R4 spurious
    iack_lvl = 3'd3;
    settle();
    chk("R4 spurious", vec, 8'd24);

    // R9 debug
    wr(3'd0, 16'h0000);
    dbg_req = 1; iack_lvl = 3'd7;
    settle();
    chk("R9 ipl", ipl, 7);
    chk("R9 vec", vec, 8'h8D);
    chk("R10 dbg wake", wake, 1);
    dbg_req = 0;

    // R8 nesting
    wr(3'd0, 16'hFFFF);
    int_req = 8'h02;
    settle();
    chk("R8 base ipl", ipl, 2);
    ack(3'd2); #1;
    chk("R8 hidden after ack", ipl, 0);
    rd(3'd5, d); chk("R8 isr one", d, 16'h04);
    ext_irq = 5'b10000;
    settle();
    chk("R8 higher preempts", ipl, 5);
    ack(3'd5); #1;
    rd(3'd5, d); chk("R8 isr two", d, 16'h24);
    chk("R8 both hidden", ipl, 0);
    dbg_req = 1; #1;
    chk("R9 over in-service", ipl, 7);
    dbg_req = 0;
    wr(3'd5, 16'h0); #1;
    rd(3'd5, d); chk("R8 eoi pops top", d, 16'h04);
    chk("R8 pin5 back", ipl, 5);
    wr(3'd5, 16'h0); #1;
    rd(3'd5, d); chk("R8 isr empty", d, 0);
    ext_irq = 0;
    settle();
    chk("R8 level2 back", ipl, 2);
    int_req = 0;

    // R6 polarity
    wr(3'd3, 16'h0100);
    ext_irq = 5'b00000;
    settle();
    rd(3'd2, d); chk("R6 active-low asserted", d[0], 1);
    chk("R6 ipl", ipl, 1);
    ext_irq = 5'b00001;
    settle();
    rd(3'd2, d); chk("R6 active-low idle", d[0], 0);

    // R7 edge sensing on pin 2
    wr(3'd3, 16'h0004);
    ext_irq = 5'b00100;
    settle();
    rd(3'd2, d); chk("R7 edge latched", d[2], 1);
    ext_irq = 0;
    settle();
    rd(3'd2, d); chk("R7 held after pin drop", d[2], 1);
    wr(3'd2, 16'h0000); #1;
    rd(3'd2, d); chk("R7 zero write ignored", d[2], 1);
    wr(3'd2, 16'h0004); #1;
    rd(3'd2, d); chk("R7 cleared", d[2], 0);
    wr(3'd3, 16'h0000);

    // R10 wake
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0100);
    int_req = 8'h08;
    #1;
    chk("R10 wake masked src", wake, 1);
    int_req = 8'h01;
    #1;
    chk("R10 not wake-enabled", wake, 0);
    int_req = 0;
    #1;
    chk("R10 idle", wake, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule